// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Miss Classification

This block is a read-only, direct-mapped cache that sits between a requester and a slower backing memory. The requester presents a 32-bit byte address. The cache returns the 32-bit word held at that aligned word address, together with a two-bit outcome code. The code marks the access as a hit, a cold miss (the indexed line held nothing), or a miss with replacement (the indexed line held a valid block under another tag). Because the code separates cold misses from conflict misses, the surrounding system can count each kind apart.

The address is split into three unsigned fields. The low bits give the byte position inside a line, the middle bits select the line, and the remaining top bits form the tag. On either kind of miss, the cache issues one line-aligned fetch and takes in every word of the line in ascending order. It then returns the requested word and, in the same cycle, writes the new tag, data and valid bit. Capacity and line length are parameters. The default is 16 KB with 16-byte lines, which gives 1024 lines of four words each.

Top module: `dm_read_cache`

## Requirements
- R1: After reset, reqReady is 1 and both rspValid and memReqValid are 0. Every line starts invalid, so the first access to any line reports outcome 01.
- R2: With default parameters, the line is selected by index = addr[13:4] and the tag is addr[31:14]. The word within the line is selected by addr[3:2]. addr[1:0] has no effect on the result.
- R3: A hit is reported with rspValid=1 and outcome 00 in the cycle after the request is accepted. No memory request is issued.
- R4: A miss on an invalid line reports outcome 01. It issues exactly one memory request, with memReqValid high for one cycle, in the cycle after acceptance. memReqAddr is the request address with its low 4 bits cleared.
- R5: Once a line is filled, it is valid and holds the new tag, so a later read of any word in that line is a hit.
- R6: A miss on a valid line whose tag differs reports outcome 10 and replaces the line. For example, 0x8014 evicts the line loaded by 0x14, and a later read of 0x1C then misses with outcome 10.
- R7: A refill takes one memRspValid beat per word, in ascending word order, and may have idle cycles between beats. The response comes in the cycle after the last beat.
- R8: rspData always equals the backing memory's word at the aligned address, whatever the outcome.
- R9: reqReady is 0 from the cycle after acceptance until the response is given. In the following cycle it returns to 1.
- R10: A fill of one index leaves every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqAddr | input | 32 | Byte address of the read |
| reqReady | output | 1 | Cache can accept a request |
| rspValid | output | 1 | Response word and outcome valid |
| rspData | output | 32 | Returned word |
| rspOutcome | output | 2 | 00 hit, 01 cold miss, 10 miss with replacement |
| memReqValid | output | 1 | Line fetch request, one cycle |
| memReqAddr | output | 32 | Line-aligned fetch address |
| memRspValid | input | 1 | One refill word present |
| memRspData | input | 32 | Refill word |

## Verification
A hit is due one cycle after the acceptance edge. A miss shows memReqValid in that same cycle, and its response follows exactly one cycle after the edge that takes the last refill beat. The bench drives each input on a falling edge and counts rising edges from the acceptance point. It samples each result on the falling edge of the cycle in which that result is due, and in the intervening cycles it checks that rspValid stays low and reqReady stays low. Refills are run both back to back and with idle gaps between beats, so that the response is tied to the last beat rather than to a fixed delay.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

  typedef enum logic [1:0] {
    OUT_HIT   = 2'b00,
    OUT_COLD  = 2'b01,
    OUT_EVICT = 2'b10
  } outcome_e;

  typedef struct packed {
    logic captureReq;
    logic latchMiss;
    logic fillWord;
    logic commitLine;
    logic respondHit;
  } strobes_t;

endpackage

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memRspValid,
  input  logic     lineHit,
  input  logic     lastBeat,
  output logic     reqReady,
  output logic     rspValid,
  output logic     memReqValid,
  output strobes_t strobes
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_FILL, ST_RESP} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobes     = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.captureReq = 1'b1;
          stateNext = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lineHit) begin
          rspValid           = 1'b1;
          strobes.respondHit = 1'b1;
          stateNext          = ST_IDLE;
        end else begin
          memReqValid       = 1'b1;
          strobes.latchMiss = 1'b1;
          stateNext         = ST_FILL;
        end
      end
      ST_FILL: begin
        if (memRspValid) begin
          strobes.fillWord = 1'b1;
          if (lastBeat) stateNext = ST_RESP;
        end
      end
      ST_RESP: begin
        rspValid           = 1'b1;
        strobes.commitLine = 1'b1;
        stateNext          = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R9: once a fetch is issued the cache stays busy and silent next cycle
  a_r9_busy_after_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> (!reqReady && !rspValid));

  // R9: a response is always followed by readiness
  a_r9_ready_after_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

endmodule

// File: rtl/dm_cache_datapath.sv
module dm_cache_datapath
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] memRspData,
  output logic              lineHit,
  output logic              lastBeat,
  output logic [WORD_W-1:0] rspData,
  output logic [1:0]        rspOutcome,
  output logic [ADDR_W-1:0] memReqAddr
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BSEL_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = OFF_W - BSEL_W;
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;

  typedef logic [WORDS-1:0][WORD_W-1:0] line_t;

  logic [ADDR_W-1:0] addrQ;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic [NUM_LINES-1:0] validQ;
  logic [TAG_W-1:0]  tagMem [NUM_LINES];
  line_t             dataMem [NUM_LINES];
  line_t             fillBuf;
  line_t             lineRd;
  logic [WSEL_W-1:0] fillCnt;
  outcome_e          outcomeQ;
  logic              lineValid;

  assign idx  = addrQ[OFF_W +: IDX_W];
  assign tag  = addrQ[ADDR_W-1 -: TAG_W];
  assign wsel = addrQ[BSEL_W +: WSEL_W];

  assign lineValid = validQ[idx];
  assign lineHit   = lineValid && (tagMem[idx] == tag);
  assign lineRd    = dataMem[idx];
  assign lastBeat  = (fillCnt == WSEL_W'(WORDS - 1));
  assign memReqAddr = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      validQ   <= '0;
      fillCnt  <= '0;
      outcomeQ <= OUT_HIT;
    end else begin
      if (strobes.captureReq) begin
        addrQ   <= reqAddr;
        fillCnt <= '0;
      end
      if (strobes.latchMiss)
        outcomeQ <= lineValid ? OUT_EVICT : OUT_COLD;
      if (strobes.fillWord)
        fillCnt <= fillCnt + 1'b1;
      if (strobes.commitLine)
        validQ[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fillWord)
      fillBuf[fillCnt] <= memRspData;
    if (strobes.commitLine) begin
      tagMem[idx]  <= tag;
      dataMem[idx] <= fillBuf;
    end
  end

  always_comb begin
    if (strobes.respondHit) begin
      rspData    = lineRd[wsel];
      rspOutcome = OUT_HIT;
    end else begin
      rspData    = fillBuf[wsel];
      rspOutcome = outcomeQ;
    end
  end

  // R5: a committed line is found as a hit on the following cycle
  a_r5_commit_then_hit: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitLine |=> lineHit);

  // R6: a miss on a valid line is remembered as a replacement
  a_r6_evict_code: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchMiss && lineValid) |=> (outcomeQ == OUT_EVICT));

endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic [1:0]        rspOutcome,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData
);

  strobes_t strobes;
  logic     lineHit;
  logic     lastBeat;

  dm_cache_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .lineHit     (lineHit),
    .lastBeat    (lastBeat),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .memReqValid (memReqValid),
    .strobes     (strobes)
  );

  dm_cache_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_BYTES (LINE_BYTES),
    .NUM_LINES  (NUM_LINES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .memRspData (memRspData),
    .lineHit    (lineHit),
    .lastBeat   (lastBeat),
    .rspData    (rspData),
    .rspOutcome (rspOutcome),
    .memReqAddr (memReqAddr)
  );

  // R3: a hit response comes exactly one cycle after acceptance
  a_r3_hit_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOutcome == OUT_HIT) |-> $past(reqValid && reqReady));

  // R7: a miss response follows a refill beat directly
  a_r7_rsp_after_beat: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOutcome != OUT_HIT) |-> $past(memRspValid));

  // R4: fetch addresses are line aligned
  a_r4_aligned_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[$clog2(LINE_BYTES)-1:0] == '0));

endmodule

// File: tb/dm_read_cache_tb.sv
`timescale 1ns/1ps
module dm_read_cache_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady;
  logic        rspValid;
  logic [31:0] rspData;
  logic [1:0]  rspOutcome;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  dm_read_cache dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .rspOutcome(rspOutcome), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData)
  );

  function automatic logic [31:0] memVal(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one read; expOut 0 hit, 1 cold, 2 replace; gap = idle cycles between beats
  task automatic doRead(input logic [31:0] a, input logic [1:0] expOut,
                        input int gap, input string req);
    logic [31:0] line;
    line = {a[31:4], 4'h0};
    @(negedge clk);
    chk(reqReady == 1'b1, {req, " ready before request"}, 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
    if (expOut == 2'b00) begin
      chk(rspValid && !memReqValid, {req, " hit response R3"},
          {30'd0, memReqValid, rspValid}, 32'd1);
      chk(rspOutcome == 2'b00, {req, " hit code R3"}, 32'(rspOutcome), 32'd0);
      chk(rspData == memVal(a), {req, " hit data R8"}, rspData, memVal(a));
    end else begin
      chk(memReqValid && !rspValid && !reqReady, {req, " fetch issued R4 R9"},
          {29'd0, reqReady, rspValid, memReqValid}, 32'd1);
      chk(memReqAddr == line, {req, " fetch address R4"}, memReqAddr, line);
      for (int w = 0; w < 4; w++) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          memRspValid = 1'b0;
          chk(!rspValid && !reqReady && !memReqValid, {req, " idle gap R7"},
              {29'd0, memReqValid, reqReady, rspValid}, 32'd0);
        end
        @(negedge clk);
        chk(!rspValid && !reqReady, {req, " busy during refill R9"},
            {30'd0, reqReady, rspValid}, 32'd0);
        memRspValid = 1'b1;
        memRspData  = memVal(line + 32'(4 * w));
      end
      @(negedge clk);
      memRspValid = 1'b0;
      chk(rspValid == 1'b1, {req, " response after last beat R7"}, 32'(rspValid), 32'd1);
      chk(rspOutcome == expOut, {req, " miss code R4 R6"}, 32'(rspOutcome), 32'(expOut));
      chk(rspData == memVal(a), {req, " miss data R8"}, rspData, memVal(a));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(reqReady && !rspValid && !memReqValid, "R1 reset outputs",
        {29'd0, memReqValid, rspValid, reqReady}, 32'd1);
    doRead(32'h0000_0014, 2'b01, 0, "R1 R4 cold line1");
    doRead(32'h0000_001C, 2'b00, 0, "R3 R2 hit word3");
    doRead(32'h0000_0034, 2'b01, 2, "R7 R10 cold line3 gapped");
    doRead(32'h0000_8014, 2'b10, 1, "R6 replace line1");
    doRead(32'h0000_0030, 2'b00, 0, "R10 line3 intact");
    doRead(32'h0000_8018, 2'b00, 0, "R5 new tag hits");
    doRead(32'h0000_001C, 2'b10, 0, "R6 replace back");
    doRead(32'h0000_0017, 2'b00, 0, "R2 low bits ignored");
    doRead(32'h0000_0010, 2'b00, 0, "R5 word0 hit");
    doRead(32'h0000_3FF0, 2'b01, 0, "R2 top index cold");
    doRead(32'h0000_3FFC, 2'b00, 0, "R2 top index hit");
    doRead(32'hFFFF_FFF8, 2'b10, 3, "R6 max tag replace");
    doRead(32'hFFFF_FFF1, 2'b00, 0, "R2 R8 max tag hit");
    doRead(32'h0000_0034, 2'b00, 0, "R10 line3 still held");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule